// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Aggregator

This block gathers up to 32 interrupt inputs into one request line for a parent controller. Each input goes through a two-flop synchroniser. A pair of per-source configuration bits then selects the trigger type: rising edge, falling edge, high level or low level. Each source has a pending bit. An edge source latches its pending bit until software writes a 1 to that bit to acknowledge it. A level source's pending bit follows the qualified input. Software can also raise any pending bit through a force register.

The pending bits are masked by an enable register and ORed together. The result drives the single request line. That line has its own programmable signalling style, either a held level or a one-cycle pulse on each rising edge of the combined request, and its own active polarity. Registers are reached through a simple word-wide port. A write is a one-cycle strobe with an address and data. A read is combinational from the address. Reset is asynchronous and active low, and it is released inside the block in step with the clock.

Top module: `trigirq_ctrl`

## Requirements
- R1: While reset is applied and directly after it, every register reads 0 and `irq_o` is 1, because the output is inactive-low with nothing enabled.
- R2: A change on `src_i` reaches a pending bit on the third rising clock edge after the change. After two edges the pending bit still holds its old value.
- R3: Source-mode bit 0 selects level detection. The pending bit then equals the synchronised input (polarity bit 1) or its inverse (polarity bit 0), one cycle later. Writing 1 to its status bit has no effect while the level stays active.
- R4: Source-mode bit 1 selects edge detection. Polarity 1 sets the pending bit on a 0-to-1 change of the synchronised input, and polarity 0 sets it on a 1-to-0 change. The bit stays set until it is cleared.
- R5: On an edge source, writing 1 to a status bit (word offset 0x04) clears that bit and writing 0 leaves it unchanged. A new edge in the same cycle as the clear wins, and the bit stays set.
- R6: Writing 1 to a bit at offset 0x18 sets the matching pending bit on the next cycle. The force offset always reads 0.
- R7: Enable (offset 0x00) bit 1 lets a pending source drive the output. Bit 0 masks it. Masked sources still record pending status.
- R8: Output mode (offset 0x10, bit 0) = 0 gives a level request that is active while any enabled pending bit is set.
- R9: Output mode 1 gives an active request for exactly one cycle each time the OR of enabled pending bits goes from 0 to 1.
- R10: Output polarity (offset 0x14, bit 0) = 1 makes `irq_o` active high. A value of 0 makes it active low.
- R11: Word offset 0x1C reads 0, and writes to it change nothing. Address bits [1:0] are ignored.
- R12: Offsets 0x00, 0x04, 0x08, 0x0C read back enable, pending status, source mode and source polarity. Offsets 0x10 and 0x14 read back their single bit in bit 0, with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt inputs, asynchronous |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Combined request toward the parent controller |

## Verification
The assertions rely on one assumption: a write strobe lasts one cycle, and the address and data are stable across the edge that captures them. The bench meets this by driving every bus signal on the falling edge and holding it for a whole cycle. The pulse-mode and hold properties also assume the configuration they sample is the one used at that edge. Random stimulus therefore changes `src_i` only on falling edges, well clear of the sampling edge. The random runs mix configuration writes, acknowledges and forces with these input changes in every trigger and output combination.

// File: rtl/trigirq_pkg.sv
package trigirq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_ENABLE = 3'd0,
    IDX_STATUS = 3'd1,
    IDX_SMODE  = 3'd2,
    IDX_SPOL   = 3'd3,
    IDX_OMODE  = 3'd4,
    IDX_OPOL   = 3'd5,
    IDX_FORCE  = 3'd6,
    IDX_SPARE  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/trigirq_rst_sync.sv
module trigirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/trigirq_sync.sv
module trigirq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/trigirq_detect.sv
module trigirq_detect #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] s_i,
  input  logic [NSRC-1:0] mode_i,
  input  logic [NSRC-1:0] pol_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] frc_i,
  output logic [NSRC-1:0] st_o
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] st_q;
  logic [NSRC-1:0] st_d;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] fall;
  logic [NSRC-1:0] lvl_hit;
  logic [NSRC-1:0] edge_hit;
  logic [NSRC-1:0] edge_hold;

  always_comb begin
    rise      = s_i & ~prev_q;
    fall      = ~s_i & prev_q;
    lvl_hit   = ~mode_i & ~(s_i ^ pol_i);
    edge_hit  = mode_i & ((pol_i & rise) | (~pol_i & fall));
    edge_hold = mode_i & st_q & ~clr_i;
    st_d      = lvl_hit | edge_hit | edge_hold | frc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      st_q   <= '0;
    end else begin
      prev_q <= s_i;
      st_q   <= st_d;
    end
  end

  assign st_o = st_q;

  // R3: an active level is reflected in the pending bit one cycle later
  assert_level_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_hit != '0) |=> ((st_q & $past(lvl_hit)) == $past(lvl_hit)));

  // R4: a set edge bit that is not being cleared stays set
  assert_edge_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hold != '0) |=> ((st_q & $past(edge_hold)) == $past(edge_hold)));
endmodule

// File: rtl/trigirq_out.sv
module trigirq_out #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] st_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            omode_i,
  input  logic            opol_i,
  output logic            irq_o
);
  logic agg;
  logic agg_q;
  logic act;

  always_comb begin
    agg = |(st_i & en_i);
    act = omode_i ? (agg & ~agg_q) : agg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) agg_q <= 1'b0;
    else        agg_q <= agg;
  end

  assign irq_o = opol_i ? act : ~act;

  // R9: in pulse mode the request is never active two cycles running
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (omode_i && act) |=> (!omode_i || !act));

  // R10: with nothing enabled pending, the line sits at its inactive level
  assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_i & en_i) == '0) |-> (irq_o == ~opol_i));
endmodule

// File: rtl/trigirq_ctrl.sv
module trigirq_ctrl
  import trigirq_pkg::*;
#(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int unsigned WORD_LSB = 2;

  logic            rst_sn;
  logic [NSRC-1:0] s_sync;
  logic [NSRC-1:0] st;
  logic [IDX_W-1:0] widx;

  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] smode_q, smode_d;
  logic [NSRC-1:0] spol_q, spol_d;
  logic            omode_q, omode_d;
  logic            opol_q, opol_d;
  logic            en_we, smode_we, spol_we, omode_we, opol_we;
  logic [NSRC-1:0] clr_vec, frc_vec;

  trigirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  trigirq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d_i(src_i), .q_o(s_sync)
  );

  assign widx = bus_addr[ADDR_W-1:WORD_LSB];

  always_comb begin
    en_we    = bus_wr && (widx == IDX_ENABLE);
    smode_we = bus_wr && (widx == IDX_SMODE);
    spol_we  = bus_wr && (widx == IDX_SPOL);
    omode_we = bus_wr && (widx == IDX_OMODE);
    opol_we  = bus_wr && (widx == IDX_OPOL);
    clr_vec  = (bus_wr && (widx == IDX_STATUS)) ? bus_wdata[NSRC-1:0] : '0;
    frc_vec  = (bus_wr && (widx == IDX_FORCE))  ? bus_wdata[NSRC-1:0] : '0;
    en_d     = bus_wdata[NSRC-1:0];
    smode_d  = bus_wdata[NSRC-1:0];
    spol_d   = bus_wdata[NSRC-1:0];
    omode_d  = bus_wdata[0];
    opol_d   = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q    <= '0;
      smode_q <= '0;
      spol_q  <= '0;
      omode_q <= 1'b0;
      opol_q  <= 1'b0;
    end else begin
      if (en_we)    en_q    <= en_d;
      if (smode_we) smode_q <= smode_d;
      if (spol_we)  spol_q  <= spol_d;
      if (omode_we) omode_q <= omode_d;
      if (opol_we)  opol_q  <= opol_d;
    end
  end

  trigirq_detect #(.NSRC(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_sn), .s_i(s_sync), .mode_i(smode_q),
    .pol_i(spol_q), .clr_i(clr_vec), .frc_i(frc_vec), .st_o(st)
  );

  trigirq_out #(.NSRC(NSRC)) u_out (
    .clk(clk), .rst_n(rst_sn), .st_i(st), .en_i(en_q),
    .omode_i(omode_q), .opol_i(opol_q), .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (widx)
      IDX_ENABLE: bus_rdata[NSRC-1:0] = en_q;
      IDX_STATUS: bus_rdata[NSRC-1:0] = st;
      IDX_SMODE:  bus_rdata[NSRC-1:0] = smode_q;
      IDX_SPOL:   bus_rdata[NSRC-1:0] = spol_q;
      IDX_OMODE:  bus_rdata[0]        = omode_q;
      IDX_OPOL:   bus_rdata[0]        = opol_q;
      default:    bus_rdata           = '0;
    endcase
  end

  // R6: forced bits are pending on the following cycle
  assert_force_sets_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (frc_vec != '0) |=> ((st & $past(frc_vec)) == $past(frc_vec)));

  // R12: configuration holds its value when not written
  assert_cfg_stable_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    (!bus_wr) |=> ($stable(en_q) && $stable(smode_q) && $stable(spol_q)));
endmodule

// File: tb/trigirq_ctrl_tb.sv
module trigirq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  trigirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  // behavioural reference state
  bit          m_r1, m_r2;
  logic [31:0] m_s1, m_s2, m_prev, m_st, m_en, m_mode, m_pol;
  bit          m_omode, m_opol, m_aggq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_st = '0;
      m_en = '0; m_mode = '0; m_pol = '0; m_omode = 0; m_opol = 0; m_aggq = 0;
    end else begin
      bit live;
      live = m_r2;
      m_r2 = m_r1;
      m_r1 = 1;
      if (live) begin
        logic [31:0] nst, clr, frc;
        int w;
        w   = int'(bus_addr) / 4;
        clr = (bus_wr && w == 1) ? bus_wdata : 32'h0;
        frc = (bus_wr && w == 6) ? bus_wdata : 32'h0;
        for (int i = 0; i < 32; i++) begin
          bit hit;
          if (m_mode[i]) begin
            if (m_pol[i]) hit = (m_s2[i] == 1) && (m_prev[i] == 0);
            else          hit = (m_s2[i] == 0) && (m_prev[i] == 1);
            nst[i] = hit || frc[i] || (m_st[i] && !clr[i]);
          end else begin
            hit = (m_s2[i] == m_pol[i]);
            nst[i] = hit || frc[i];
          end
        end
        m_aggq = ((m_st & m_en) != 0);
        m_st   = nst;
        if (bus_wr && w == 0) m_en    = bus_wdata;
        if (bus_wr && w == 2) m_mode  = bus_wdata;
        if (bus_wr && w == 3) m_pol   = bus_wdata;
        if (bus_wr && w == 4) m_omode = bus_wdata[0];
        if (bus_wr && w == 5) m_opol  = bus_wdata[0];
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = src_i;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (int'(a) / 4)
      0: return m_en;
      1: return m_st;
      2: return m_mode;
      3: return m_pol;
      4: return {31'h0, m_omode};
      5: return {31'h0, m_opol};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic m_irq();
    bit agg, act;
    agg = ((m_st & m_en) != 0);
    act = m_omode ? (agg && !m_aggq) : agg;
    return m_opol ? act : !act;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (cmp_on && rst_n) begin
      check({cur_req, " rdata"}, bus_rdata, m_read(bus_addr));
      check({cur_req, " irq"}, {31'h0, irq_o}, {31'h0, m_irq()});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic sel(input logic [4:0] a);
    @(negedge clk);
    bus_addr = a;
  endtask

  task automatic rnd_run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      if ($urandom_range(0, 3) == 0) src_i = $urandom;
      case ($urandom_range(0, 7))
        0: begin bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = $urandom; end
        1: begin bus_wr = 1'b1; bus_addr = 5'h18; bus_wdata = $urandom & $urandom; end
        2: begin bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = $urandom; end
        default: bus_addr = 5'($urandom_range(0, 31));
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1 irq in reset", {31'h0, irq_o}, 32'h1);
    check("R1 status in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    for (int a = 0; a < 32; a += 4) begin
      sel(5'(a));
      #1;
      check("R1 reg zero", bus_rdata & ((a == 4) ? 32'h0 : 32'hFFFF_FFFF), 32'h0);
    end
    #1 check("R1 idle irq", {31'h0, irq_o}, 32'h1);

    // R12: read-back of configuration
    cur_req = "R12";
    wr(5'h08, 32'hFFFF_0000);
    wr(5'h0C, 32'h00FF_00FF);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h14, 32'h0000_0002);
    sel(5'h08); #1 check("R12 smode", bus_rdata, 32'hFFFF_0000);
    sel(5'h10); #1 check("R12 omode bit0 only", bus_rdata, 32'h1);
    sel(5'h15); #1 check("R11 low addr bits ignored", bus_rdata, 32'h0);

    // R11: spare offset
    cur_req = "R11";
    wr(5'h1C, 32'hDEAD_BEEF);
    sel(5'h1C); #1 check("R11 spare reads 0", bus_rdata, 32'h0);
    sel(5'h08); #1 check("R11 spare write ignored", bus_rdata, 32'hFFFF_0000);

    // R2: synchroniser latency on a high-level source
    cur_req = "R2";
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
    wr(5'h04, 32'hFFFF_FFFF);
    sel(5'h04);
    @(negedge clk); src_i = 32'h1;
    @(negedge clk); @(negedge clk); #1
    check("R2 not yet after two edges", bus_rdata & 32'h1, 32'h0);
    @(negedge clk); #1
    check("R2 set after third edge", bus_rdata & 32'h1, 32'h1);

    // R3: W1C has no effect on an active level
    cur_req = "R3";
    wr(5'h04, 32'h1);
    sel(5'h04); #1 check("R3 level not cleared", bus_rdata & 32'h1, 32'h1);

    // R4/R5: rising edge source latches and is acknowledged
    cur_req = "R4";
    wr(5'h08, 32'h1);
    src_i = 32'h0;
    repeat (4) @(negedge clk);
    wr(5'h04, 32'h1);
    sel(5'h04); #1 check("R5 edge cleared", bus_rdata & 32'h1, 32'h0);
    src_i = 32'h1;
    repeat (6) @(negedge clk);
    #1 check("R4 edge latched", bus_rdata & 32'h1, 32'h1);
    cur_req = "R5";
    wr(5'h04, 32'h0);
    sel(5'h04); #1 check("R5 write 0 keeps", bus_rdata & 32'h1, 32'h1);

    // R6: force
    cur_req = "R6";
    wr(5'h18, 32'h0000_0100);
    sel(5'h18); #1 check("R6 force reads 0", bus_rdata, 32'h0);

    // R9: pulse mode, active high
    cur_req = "R9";
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h10, 32'h1);
    wr(5'h14, 32'h1);
    wr(5'h00, 32'h0000_0002);
    @(negedge clk); #1 check("R9 idle", {31'h0, irq_o}, 32'h0);
    wr(5'h18, 32'h2);
    #1 check("R9 pulse high", {31'h0, irq_o}, 32'h1);
    @(negedge clk); #1 check("R9 pulse one cycle", {31'h0, irq_o}, 32'h0);

    // random sweeps over every trigger/output combination
    for (int cfg = 0; cfg < 16; cfg++) begin
      case (cfg % 4)
        0: cur_req = "R3";
        1: cur_req = "R4";
        2: cur_req = "R7";
        default: cur_req = "R8";
      endcase
      if (cfg >= 8) cur_req = (cfg % 2) ? "R10" : "R9";
      wr(5'h08, (cfg & 1) ? 32'hFFFF_FFFF : ((cfg & 4) ? 32'hA5A5_5A5A : 32'h0));
      wr(5'h0C, (cfg & 2) ? 32'hFFFF_FFFF : 32'h0F0F_3C3C);
      wr(5'h10, 32'(cfg >> 3));
      wr(5'h14, 32'((cfg >> 2) & 1));
      rnd_run(600);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule